// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block finds jets in one crate slice of the calorimeter. It takes a grid of regional energies with `ETA_N` columns in eta and `PHI_N` rows in phi. Around that grid the neighbouring slices supply a one-region halo on every side. The column next to the eta=0 seam carries the copy of the regions across the seam. Every owned region is the centre of a 3x3 window. A jet is declared where the centre energy is nonzero and is a local maximum of its window. The jet energy is the sum of the window, and each jet is tagged central, forward or tau-like.

The halo regions count in every window sum and in every local-maximum comparison. They can never be a centre, so data that two slices share never gives the same jet twice. The found jets are ranked by energy, and at most four of them are presented in descending order. The block takes a whole grid in one cycle when `in_valid` is high and registers the ranked result.

Grid layout: the extended grid has `ETA_N+2` columns (x) and `PHI_N+2` rows (y). Cell (x,y) occupies `in_et[((y*(ETA_N+2))+x)*10 +: 10]` and `in_narrow[y*(ETA_N+2)+x]`. Owned region (eta i, phi j) sits at x=i+1, y=j+1. Column x=0 lies on the seam side and column x=ETA_N+1 lies beyond the outer edge.

Top module: `jet_window_finder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. All result outputs change only in the cycle after `in_valid` and hold their values otherwise.
- R2: While `rst_n` is low, `out_valid` is 0, `out_found` is 0 and every slot's energy, eta, phi and category are 0.
- R3: Only owned regions (x=1..ETA_N, y=1..PHI_N) can be jet centres. Halo cells never yield a jet, but they take part in the sums and comparisons of the windows that cover them. The reported eta and phi are owned indices (0-based, eta 0 next to the seam).
- R4: A centre is a jet only if its energy is nonzero. It must be >= each neighbour that comes earlier in scan order (smaller y, or the same y and smaller x) and strictly > each later neighbour. On a plateau of equal values only the latest cell in scan order is a jet.
- R5: The jet energy is the sum of the nine window energies. If that sum exceeds 4095, it saturates to 4095.
- R6: The category is 1 (forward) when the centre eta index is ETA_N-1. Otherwise it is 2 (tau) when the narrow bits of all nine window cells are set, and 0 (central) in every other case.
- R7: Slots 0..3 hold up to four jets in descending energy. Equal energies are ordered by smaller index j*ETA_N+i first. `out_found` is set for the filled slots from slot 0 upward. An unfilled slot reads energy, eta, phi and category 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Grid on `in_et`/`in_narrow` is evaluated this cycle |
| in_et | input | (ETA_N+2)*(PHI_N+2)*10 | Regional energies of the extended grid, 10 bits each |
| in_narrow | input | (ETA_N+2)*(PHI_N+2) | Narrow-shower flag per extended-grid cell |
| out_valid | output | 1 | Result registers updated in this cycle |
| out_et | output | NOUT*12 | Jet energy per slot, slot 0 in the low bits |
| out_eta | output | NOUT*$clog2(ETA_N) | Owned eta index of each slot's centre |
| out_phi | output | NOUT*$clog2(PHI_N) | Owned phi index of each slot's centre |
| out_cat | output | NOUT*2 | Category per slot: 0 central, 1 forward, 2 tau |
| out_found | output | NOUT | Slot holds a jet |

## Verification
The assertions assume that `in_valid` and the grid inputs are settled at every rising edge and that reset is asserted before the first clock. The bench drives all inputs on falling edges and releases reset only after several cycles, so both assumptions hold. ETA_N and PHI_N must be at least 2, and the bench uses the defaults. Every grid the bench builds places deposits at chosen cells, leaves the rest zero, and holds the narrow bits uniform except for one deliberate hole. This keeps every expected window sum, peak and ranking derivable by hand.

// File: rtl/jet_window_finder.sv
module jet_window_finder #(
  parameter int ETA_N = 5,
  parameter int PHI_N = 4,
  parameter int EW    = 10,
  parameter int JW    = 12,
  parameter int NOUT  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [(ETA_N+2)*(PHI_N+2)*EW-1:0]    in_et,
  input  logic [(ETA_N+2)*(PHI_N+2)-1:0]       in_narrow,
  output logic                                 out_valid,
  output logic [NOUT*JW-1:0]                   out_et,
  output logic [NOUT*$clog2(ETA_N)-1:0]        out_eta,
  output logic [NOUT*$clog2(PHI_N)-1:0]        out_phi,
  output logic [NOUT*2-1:0]                    out_cat,
  output logic [NOUT-1:0]                      out_found
);
  localparam int XW    = ETA_N + 2;
  localparam int NC    = ETA_N * PHI_N;
  localparam int SW    = EW + 4;
  localparam int ETA_W = $clog2(ETA_N);
  localparam int PHI_W = $clog2(PHI_N);
  localparam int JMAX  = (1 << JW) - 1;
  localparam logic [1:0] CAT_CEN = 2'd0;
  localparam logic [1:0] CAT_FWD = 2'd1;
  localparam logic [1:0] CAT_TAU = 2'd2;

  logic [JW-1:0] c_et  [NC];
  logic [1:0]    c_cat [NC];
  logic [NC-1:0] c_ok;

  for (genvar k = 0; k < NC; k++) begin : g_win
    localparam int I = k % ETA_N;
    localparam int J = k / ETA_N;
    localparam int X = I + 1;
    localparam int Y = J + 1;
    logic [SW-1:0] sum;
    logic          peak, nar;

    always_comb begin
      int idx;
      logic [EW-1:0] v, ctr;
      ctr  = in_et[(Y*XW + X)*EW +: EW];
      sum  = '0;
      peak = (ctr != '0);
      nar  = 1'b1;
      for (int dy = -1; dy <= 1; dy++) begin
        for (int dx = -1; dx <= 1; dx++) begin
          idx = (Y + dy)*XW + X + dx;
          v   = in_et[idx*EW +: EW];
          sum = sum + SW'(v);
          nar = nar & in_narrow[idx];
          if (dy != 0 || dx != 0) begin
            if (dy < 0 || (dy == 0 && dx < 0)) peak = peak & (ctr >= v);
            else                               peak = peak & (ctr > v);
          end
        end
      end
    end

    assign c_et[k]  = (sum > SW'(JMAX)) ? JW'(JMAX) : sum[JW-1:0];
    assign c_ok[k]  = peak;
    assign c_cat[k] = (I == ETA_N-1) ? CAT_FWD : (nar ? CAT_TAU : CAT_CEN);
  end

  logic [NOUT*JW-1:0]    n_et;
  logic [NOUT*ETA_W-1:0] n_eta;
  logic [NOUT*PHI_W-1:0] n_phi;
  logic [NOUT*2-1:0]     n_cat;
  logic [NOUT-1:0]       n_found;

  always_comb begin
    int r;
    n_et = '0; n_eta = '0; n_phi = '0; n_cat = '0; n_found = '0;
    for (int k = 0; k < NC; k++) begin
      r = 0;
      for (int m = 0; m < NC; m++)
        if (c_ok[m] && (c_et[m] > c_et[k] || (c_et[m] == c_et[k] && m < k))) r++;
      if (c_ok[k] && r < NOUT) begin
        n_et[r*JW +: JW]        = c_et[k];
        n_eta[r*ETA_W +: ETA_W] = ETA_W'(k % ETA_N);
        n_phi[r*PHI_W +: PHI_W] = PHI_W'(k / ETA_N);
        n_cat[r*2 +: 2]         = c_cat[k];
        n_found[r]              = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_et    <= '0;
      out_eta   <= '0;
      out_phi   <= '0;
      out_cat   <= '0;
      out_found <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_et    <= n_et;
        out_eta   <= n_eta;
        out_phi   <= n_phi;
        out_cat   <= n_cat;
        out_found <= n_found;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_et) && $stable(out_found) && $stable(out_cat)); // R1

  for (genvar s = 0; s < NOUT; s++) begin : g_chk
    AST_OWNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      out_found[s] |-> (out_eta[s*ETA_W +: ETA_W] < ETA_W'(ETA_N)) &&
                       (int'(out_phi[s*PHI_W +: PHI_W]) < PHI_N)); // R3
    AST_NONZERO_JET: assert property (@(posedge clk) disable iff (!rst_n)
      out_found[s] |-> out_et[s*JW +: JW] != '0); // R4
    AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !out_found[s] |-> out_et[s*JW +: JW] == '0 && out_cat[s*2 +: 2] == '0); // R7
    AST_FWD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_found[s] && out_eta[s*ETA_W +: ETA_W] == ETA_W'(ETA_N-1) |->
      out_cat[s*2 +: 2] == CAT_FWD); // R6
    AST_TAU_INNER: assert property (@(posedge clk) disable iff (!rst_n)
      out_found[s] && out_cat[s*2 +: 2] == CAT_TAU |->
      out_eta[s*ETA_W +: ETA_W] != ETA_W'(ETA_N-1)); // R6
    if (s < NOUT-1) begin : g_ord
      AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        out_found[s+1] |-> out_found[s] &&
        out_et[s*JW +: JW] >= out_et[(s+1)*JW +: JW]); // R7
    end
  end
endmodule

// File: tb/tb_jet_window_finder.sv
`timescale 1ns/1ps
module tb_jet_window_finder;
  localparam int EN = 5, PN = 4, XW = EN + 2, YW = PN + 2, NCELL = XW * YW;

  typedef struct packed { logic [2:0] x; logic [2:0] y; logic [9:0] v; } dep_t;
  typedef struct packed {
    logic nar; dep_t d0, d1, d2, d3, d4;
    logic [2:0] nf; logic [11:0] e0, e1, e2, e3;
    logic [2:0] eta; logic [1:0] phi; logic [1:0] cat;
  } vec_t;

  function automatic dep_t D(int x, int y, int v);
    return '{x: 3'(x), y: 3'(y), v: 10'(v)};
  endfunction

  function automatic vec_t V(bit n, dep_t a, dep_t b, dep_t c, dep_t d, dep_t e,
                             int nf, int e0, int e1, int e2, int e3,
                             int eta, int phi, int cat);
    return '{nar: n, d0: a, d1: b, d2: c, d3: d, d4: e, nf: 3'(nf),
             e0: 12'(e0), e1: 12'(e1), e2: 12'(e2), e3: 12'(e3),
             eta: 3'(eta), phi: 2'(phi), cat: 2'(cat)};
  endfunction

  localparam dep_t Z = '0;
  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    V(0, D(3,1,100), Z, Z, Z, Z,                       1, 100, 0, 0, 0, 2, 0, 0),
    V(0, D(0,1,200), Z, Z, Z, Z,                       0, 0, 0, 0, 0, 0, 0, 0),
    V(0, D(0,1,200), D(1,1,50), Z, Z, Z,               0, 0, 0, 0, 0, 0, 0, 0),
    V(0, D(1,1,300), D(0,2,100), Z, Z, Z,              1, 400, 0, 0, 0, 0, 0, 0),
    V(0, D(5,2,77), Z, Z, Z, Z,                        1, 77, 0, 0, 0, 4, 1, 1),
    V(0, D(3,1,1023), D(2,1,1022), D(4,1,1022), D(3,2,1022), D(2,2,1022),
                                                       1, 4095, 0, 0, 0, 2, 0, 0),
    V(1, D(2,1,40), Z, Z, Z, Z,                        1, 40, 0, 0, 0, 1, 0, 2),
    V(1, D(5,1,60), Z, Z, Z, Z,                        1, 60, 0, 0, 0, 4, 0, 1),
    V(0, D(2,1,500), D(3,1,500), Z, Z, Z,              1, 1000, 0, 0, 0, 2, 0, 0),
    V(0, D(1,1,10), D(5,2,30), D(3,1,20), Z, Z,        3, 30, 20, 10, 0, 4, 1, 1),
    V(0, D(1,1,5), D(3,1,6), D(5,1,7), D(1,3,8), D(3,3,9),
                                                       4, 9, 8, 7, 6, 2, 2, 0),
    V(0, D(1,1,50), D(3,3,50), Z, Z, Z,                2, 50, 50, 0, 0, 0, 0, 0),
    V(0, D(2,4,100), D(2,5,150), Z, Z, Z,              0, 0, 0, 0, 0, 0, 0, 0)
  };

  logic clk = 1'b0, rst_n, in_valid;
  logic [NCELL*10-1:0] in_et;
  logic [NCELL-1:0] in_narrow;
  logic out_valid;
  logic [47:0] out_et;
  logic [11:0] out_eta;
  logic [7:0] out_phi, out_cat;
  logic [3:0] out_found;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  jet_window_finder dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_et(in_et), .in_narrow(in_narrow), .out_valid(out_valid), .out_et(out_et),
    .out_eta(out_eta), .out_phi(out_phi), .out_cat(out_cat), .out_found(out_found));

  task automatic check(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put(dep_t d);
    if (d.v != 0) in_et[(int'(d.y)*XW + int'(d.x))*10 +: 10] = d.v;
  endtask

  task automatic load(vec_t t);
    in_et = '0;
    in_narrow = t.nar ? '1 : '0;
    put(t.d0); put(t.d1); put(t.d2); put(t.d3); put(t.d4);
  endtask

  task automatic apply();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_et = '0; in_narrow = '0;
    repeat (3) @(negedge clk);
    check("R2 reset out_valid", int'(out_valid), 0);
    check("R2 reset out_found", int'(out_found), 0);
    check("R2 reset out_et", int'(out_et != '0), 0);
    check("R2 reset out_cat", int'(out_cat), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VT[i]);
      @(negedge clk);
      apply();
      check($sformatf("R1 vector %0d out_valid", i), int'(out_valid), 1);
      check($sformatf("R3 R4 R7 vector %0d found mask", i), int'(out_found),
            (1 << VT[i].nf) - 1);
      check($sformatf("R5 R7 vector %0d slot0 et", i), int'(out_et[11:0]), int'(VT[i].e0));
      check($sformatf("R5 R7 vector %0d slot1 et", i), int'(out_et[23:12]), int'(VT[i].e1));
      check($sformatf("R7 vector %0d slot2 et", i), int'(out_et[35:24]), int'(VT[i].e2));
      check($sformatf("R7 vector %0d slot3 et", i), int'(out_et[47:36]), int'(VT[i].e3));
      if (VT[i].nf != 0) begin
        check($sformatf("R3 R7 vector %0d slot0 eta", i), int'(out_eta[2:0]), int'(VT[i].eta));
        check($sformatf("R3 R7 vector %0d slot0 phi", i), int'(out_phi[1:0]), int'(VT[i].phi));
        check($sformatf("R6 vector %0d slot0 cat", i), int'(out_cat[1:0]), int'(VT[i].cat));
      end
      @(negedge clk);
      check($sformatf("R1 vector %0d out_valid drop", i), int'(out_valid), 0);
    end

    // R1: new grid without in_valid must not disturb the held result
    load(VT[0]);
    @(negedge clk);
    apply();
    load(VT[3]);
    repeat (2) @(negedge clk);
    check("R1 hold out_valid", int'(out_valid), 0);
    check("R1 hold slot0 et", int'(out_et[11:0]), 100);
    check("R1 hold slot0 eta", int'(out_eta[2:0]), 2);

    // R6: one narrow bit missing inside the window leaves the jet central
    load(V(1, D(2,1,40), Z, Z, Z, Z, 1, 40, 0, 0, 0, 1, 0, 0));
    in_narrow[2*XW + 3] = 1'b0;
    @(negedge clk);
    apply();
    check("R6 partial narrow cat", int'(out_cat[1:0]), 0);
    check("R6 partial narrow et", int'(out_et[11:0]), 40);

    // R2: reset mid-run clears a populated result
    load(VT[10]);
    @(negedge clk);
    apply();
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 re-reset out_found", int'(out_found), 0);
    check("R2 re-reset out_et", int'(out_et != '0), 0);
    rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule